// File: doc/BRIEF.md
# Compare-Match Interval Timer with Event Counting

This block is an 8-bit up-counter peripheral that produces a periodic interrupt request. The counter gets its count pulses from one of two sources. In timer mode they come from the system clock through a programmable prescaler. In event mode they come from rising edges on an external input pin. The event input is synchronized into the system clock domain first. Event mode only works while a separate pin-function enable is high.

On each count pulse the counter compares its value with a compare register. On a match it returns to zero and raises a sticky interrupt flag, so one interval lasts (compare + 1) count pulses. Software programs the block through a small write port that has two registers, control and compare. It reads the live count and clears the flag with a dedicated input.

A small state machine sequences the counter through three states:

- `ST_STOP`: the counter is idle.
- `ST_WAIT_EDGE`: event mode is armed and waits for the first external edge.
- `ST_COUNT`: count pulses are accepted.

Its transitions are:

- GO_TIMER: `ST_STOP` to `ST_COUNT`, taken when the run bit is set with the timer source.
- GO_EVENT: `ST_STOP` to `ST_WAIT_EDGE`, taken when the run bit is set with the event source.
- FIRST_EDGE: `ST_WAIT_EDGE` to `ST_COUNT`, taken on the first enabled edge.
- HALT: any running state to `ST_STOP`, taken when the run bit is clear.
- RELOAD: any state to `ST_STOP`, taken on every control write.

Top module: `cmt_timer`

## Requirements
- R1: After reset the count reads 0, the flag is 0, the compare register holds 0 and the control register holds 0, which means stopped.
- R2: The control register is written at address 0. Bits [2:0] select the prescaler ratio: codes 0 to 6 divide by 2, 4, 8, 32, 128, 512 and 2048, and code 7 gives no count pulses. Bit 3 selects the source (0 for timer, 1 for event). Bit 4 is the run bit.
- R3: On a count pulse where the count equals the compare register (written at address 1), the count goes to 0 and the flag is set. Otherwise the count increments. The interval between flags is therefore ratio x (compare + 1) clocks in timer mode.
- R4: The flag stays set until `irq_clr_i` is asserted. If a clear and a match fall in the same cycle, the flag ends up set.
- R5: In event mode the first rising edge after start only begins counting. Each later rising edge is one count pulse.
- R6: While `ev_pin_en_i` is 0, edges on `ev_i` have no effect on the count or the flag.
- R7: An event input that toggles on every system clock cycle (rising edges at half the clock rate) is counted without losing edges.
- R8: Any control write clears the count and the prescaler in the next cycle. Counting restarts from the new settings.
- R9: A compare write takes effect at once. If the new value is below the current count, the counter runs through 255 and wraps to 0 before it can match.
- R10: With the compare register left at its reset value of 0, the flag is set on every count pulse and the count stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Register select: 0 control, 1 compare |
| wr_data_i | input | 8 | Write data |
| ev_i | input | 1 | External event input, asynchronous |
| ev_pin_en_i | input | 1 | Pin-function enable for the event input |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| irq_o | output | 1 | Sticky interrupt request flag |
| count_o | output | 8 | Current counter value |

## Verification
The hardest case to reach from the ports is a flag clear that lands on the same clock edge as a new match. The stimulus sets the compare register to 0 and selects divide-by-2, so a match happens on every second clock. It then holds the clear input high over many cycles. With clear held, the flag is seen set on exactly half of the sampled cycles, which shows that the match wins every collision. The wrap-through-255 case is reached by lowering the compare value below a running count and tracking the largest count seen before the flag rises.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    localparam int DIV_W = 11;

    typedef enum logic [1:0] {
        ST_STOP      = 2'd0,
        ST_WAIT_EDGE = 2'd1,
        ST_COUNT     = 2'd2
    } cmt_state_e;

    typedef struct packed {
        logic       run;
        logic       src_ext;
        logic [2:0] div_sel;
    } cmt_ctrl_t;

    localparam int CTRL_W = $bits(cmt_ctrl_t);

    // Terminal value of the prescaler for each ratio code.
    function automatic logic [DIV_W-1:0] div_last(input logic [2:0] sel);
        logic [DIV_W-1:0] r;
        unique case (sel)
            3'd0:    r = DIV_W'(1);
            3'd1:    r = DIV_W'(3);
            3'd2:    r = DIV_W'(7);
            3'd3:    r = DIV_W'(31);
            3'd4:    r = DIV_W'(127);
            3'd5:    r = DIV_W'(511);
            default: r = DIV_W'(2047);
        endcase
        return r;
    endfunction

    function automatic logic div_valid(input logic [2:0] sel);
        return sel != 3'd7;
    endfunction

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
    import cmt_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       clr_i,
    input  logic       en_i,
    input  logic [2:0] sel_i,
    output logic       tick_o
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] last;

    assign last   = div_last(sel_i);
    assign tick_o = en_i && div_valid(sel_i) && (div_q == last);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            div_q <= '0;
        end else if (clr_i || !en_i) begin
            div_q <= '0;
        end else if (div_q == last) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    // R2: the smallest ratio is 2, so two ticks never come back to back
    a_r2_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);

endmodule

// File: rtl/cmt_event_sync.sv
module cmt_event_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ev_i,
    output logic rise_o
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) sync_q[g] <= 1'b0;
                    else         sync_q[g] <= ev_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) sync_q[g] <= 1'b0;
                    else         sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= sync_q[STAGES-1];
    end

    assign rise_o = sync_q[STAGES-1] & ~prev_q;

    // R7: a rising-edge pulse lasts one clock, so edges at half the clock rate stay separate
    a_r7_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);

endmodule

// File: rtl/cmt_counter.sv
module cmt_counter
    import cmt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ctrl_wr_i,
    input  cmt_ctrl_t        ctrl_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             pre_tick_i,
    input  logic             ev_rise_i,
    input  logic             pin_en_i,
    input  logic             irq_clr_i,
    output logic             pre_en_o,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o
);

    cmt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             irq_q;
    logic             ev_ok;
    logic             tick;
    logic             hit;

    assign ev_ok = ev_rise_i & pin_en_i;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_STOP;
        else         state_q <= state_d;
    end

    // Transitions: GO_TIMER, GO_EVENT, FIRST_EDGE, HALT, RELOAD
    always_comb begin
        state_d = state_q;
        if (ctrl_wr_i) begin
            state_d = ST_STOP;
        end else begin
            unique case (state_q)
                ST_STOP: begin
                    if (ctrl_i.run) state_d = ctrl_i.src_ext ? ST_WAIT_EDGE : ST_COUNT;
                end
                ST_WAIT_EDGE: begin
                    if (!ctrl_i.run) state_d = ST_STOP;
                    else if (ev_ok)  state_d = ST_COUNT;
                end
                ST_COUNT: begin
                    if (!ctrl_i.run) state_d = ST_STOP;
                end
                default: state_d = ST_STOP;
            endcase
        end
    end

    assign pre_en_o = (state_q == ST_COUNT) && !ctrl_i.src_ext;
    assign tick     = (state_q == ST_COUNT) && (ctrl_i.src_ext ? ev_ok : pre_tick_i);
    assign hit      = (cnt_q == cmp_i);

    // Outputs: count and sticky flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            if (ctrl_wr_i)      cnt_q <= '0;
            else if (tick)      cnt_q <= hit ? '0 : cnt_q + CNT_W'(1);

            if (tick && hit)    irq_q <= 1'b1;
            else if (irq_clr_i) irq_q <= 1'b0;
        end
    end

    assign count_o = cnt_q;
    assign irq_o   = irq_q;

    // R3: a match on a count pulse clears the counter and raises the flag
    a_r3_match_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick && hit && !ctrl_wr_i) |=> (cnt_q == '0) && irq_q);

    // R4: without a clear the flag holds
    a_r4_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_q && !irq_clr_i) |=> irq_q);

    // R5: no counting while waiting for the first edge
    a_r5_wait_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_WAIT_EDGE) |-> (cnt_q == '0));

    // R6: with the pin disabled, event mode leaves the count alone
    a_r6_pin_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_i.src_ext && !pin_en_i && !ctrl_wr_i) |=> $stable(cnt_q));

    // R8: a control write zeroes the counter
    a_r8_ctrl_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_wr_i |=> (cnt_q == '0));

    // R9: the count only steps by one, wraps to zero, or holds
    a_r9_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (cnt_q == $past(cnt_q) + CNT_W'(1)) || (cnt_q == '0) || $stable(cnt_q));

endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
    import cmt_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic             wr_addr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic             ev_i,
    input  logic             ev_pin_en_i,
    input  logic             irq_clr_i,
    output logic             irq_o,
    output logic [CNT_W-1:0] count_o
);

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_CMP  = 1'b1;

    cmt_ctrl_t        ctrl_q;
    logic [CNT_W-1:0] cmp_q;
    logic             ctrl_wr;
    logic             cmp_wr;
    logic             pre_en;
    logic             pre_tick;
    logic             ev_rise;

    assign ctrl_wr = wr_en_i && (wr_addr_i == ADDR_CTRL);
    assign cmp_wr  = wr_en_i && (wr_addr_i == ADDR_CMP);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q <= '0;
            cmp_q  <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= cmt_ctrl_t'(wr_data_i[CTRL_W-1:0]);
            if (cmp_wr)  cmp_q  <= wr_data_i;
        end
    end

    cmt_prescaler u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (ctrl_wr),
        .en_i   (pre_en),
        .sel_i  (ctrl_q.div_sel),
        .tick_o (pre_tick)
    );

    cmt_event_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ev_i   (ev_i),
        .rise_o (ev_rise)
    );

    cmt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ctrl_wr_i  (ctrl_wr),
        .ctrl_i     (ctrl_q),
        .cmp_i      (cmp_q),
        .pre_tick_i (pre_tick),
        .ev_rise_i  (ev_rise),
        .pin_en_i   (ev_pin_en_i),
        .irq_clr_i  (irq_clr_i),
        .pre_en_o   (pre_en),
        .count_o    (count_o),
        .irq_o      (irq_o)
    );

    // R9: a compare write lands in the next cycle
    a_r9_cmp_immediate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmp_wr |=> (cmp_q == $past(wr_data_i)));

    // R1: the registers hold their reset values until written
    a_r1_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctrl_wr |=> $stable(ctrl_q));

endmodule

// File: tb/test_cmt_timer.sv
module test_cmt_timer;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 150000;
    localparam int NVEC       = 8;

    // {ratio code[26:24], compare[23:16], expected interval in clocks[15:0]}
    localparam logic [26:0] VEC [NVEC] = '{
        {3'd0, 8'd5,   16'd12},
        {3'd1, 8'd9,   16'd40},
        {3'd2, 8'd3,   16'd32},
        {3'd3, 8'd4,   16'd160},
        {3'd4, 8'd1,   16'd256},
        {3'd5, 8'd0,   16'd512},
        {3'd6, 8'd2,   16'd6144},
        {3'd3, 8'd124, 16'd4000}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ev = 1'b0;
    logic       pin_en = 1'b0;
    logic       irq_clr = 1'b0;
    logic       irq;
    logic [7:0] count;

    int cyc = 0;
    int total = 0;
    int bad = 0;

    cmt_timer i_cmt_timer (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .ev_i        (ev),
        .ev_pin_en_i (pin_en),
        .irq_clr_i   (irq_clr),
        .irq_o       (irq),
        .count_o     (count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        wait (cyc >= WDOG_LIMIT);
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d cycles expected<%0d", cyc, WDOG_LIMIT);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clr_pulse();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic wait_irq(output int t);
        int g = 0;
        while (!irq && g < 20000) begin
            @(negedge clk);
            g++;
        end
        t = cyc;
    endtask

    task automatic measure(output int per);
        int t0;
        int t1;
        wait_irq(t0);
        clr_pulse();
        wait_irq(t1);
        per = t1 - t0;
    endtask

    task automatic slow_edge();
        ev = 1'b1;
        repeat (2) @(negedge clk);
        ev = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int per;
        int mx;
        int ones;
        int g;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 count", count, 0);
        chk("R1 flag", irq, 0);
        repeat (20) @(negedge clk);
        chk("R1 stopped", count, 0);

        // R10 compare at reset value 0, divide by 2
        wr(1'b0, 8'h10);
        measure(per);
        chk("R10 interval", per, 2);
        chk("R10 count", count, 0);

        // R2 R3 table of ratios and compare values
        for (int i = 0; i < NVEC; i++) begin
            wr(1'b1, VEC[i][23:16]);
            wr(1'b0, {3'b000, 2'b10, VEC[i][26:24]});
            clr_pulse();
            measure(per);
            chk($sformatf("R2 R3 vector %0d", i), per, int'(VEC[i][15:0]));
        end

        // R2 code 7 yields no pulses
        wr(1'b0, 8'h17);
        repeat (100) @(negedge clk);
        chk("R2 code7", count, 0);

        // R4 match wins over a held clear
        wr(1'b1, 8'd0);
        wr(1'b0, 8'h10);
        repeat (10) @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        ones = 0;
        for (int k = 0; k < 10; k++) begin
            if (irq) ones++;
            @(negedge clk);
        end
        irq_clr = 1'b0;
        chk("R4 match beats clear", ones, 5);

        // R5 event counting, first edge only starts
        pin_en = 1'b1;
        wr(1'b1, 8'd3);
        wr(1'b0, 8'h18);
        clr_pulse();
        slow_edge();
        repeat (4) @(negedge clk);
        chk("R5 first edge", count, 0);
        slow_edge();
        slow_edge();
        repeat (4) @(negedge clk);
        chk("R5 two edges", count, 2);
        chk("R5 no flag yet", irq, 0);
        slow_edge();
        slow_edge();
        repeat (4) @(negedge clk);
        chk("R5 flag", irq, 1);
        chk("R5 restart", count, 0);

        // R4 flag holds without clear
        repeat (20) @(negedge clk);
        chk("R4 sticky", irq, 1);
        clr_pulse();
        chk("R4 cleared", irq, 0);

        // R7 edges at half the clock rate
        wr(1'b1, 8'd255);
        wr(1'b0, 8'h18);
        for (int k = 0; k < 202; k++) begin
            ev = ~ev;
            @(negedge clk);
        end
        ev = 1'b0;
        repeat (6) @(negedge clk);
        chk("R7 max rate", count, 100);

        // R6 pin disabled ignores edges
        pin_en = 1'b0;
        wr(1'b0, 8'h18);
        clr_pulse();
        for (int k = 0; k < 5; k++) slow_edge();
        repeat (4) @(negedge clk);
        chk("R6 count", count, 0);
        chk("R6 flag", irq, 0);
        pin_en = 1'b1;

        // R9 compare lowered below count wraps through 255
        wr(1'b1, 8'd255);
        wr(1'b0, 8'h10);
        clr_pulse();
        repeat (60) @(negedge clk);
        wr(1'b1, 8'd5);
        mx = 0;
        g = 0;
        while (!irq && g < 2000) begin
            if (int'(count) > mx) mx = int'(count);
            @(negedge clk);
            g++;
        end
        chk("R9 wrapped max", mx, 255);
        chk("R9 flag", irq, 1);

        // R8 control write clears the running count
        clr_pulse();
        repeat (21) @(negedge clk);
        wr(1'b0, 8'h10);
        chk("R8 cleared", count, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule